// File: doc/BRIEF.md
# Programmable Down-Counter Channel

This block is a single 16-bit down-counter with a byte-wide host port. A host writes a control byte to pick how the count is accessed and which waveform the output makes. It then loads a start value one or two bytes at a time, and reads the count back through the same port. The counter advances on falling edges of a slow count clock, `cntClk`, which is sampled by the system clock `clk`. The `gate` input either enables counting or acts as a trigger, depending on the mode.

A control byte with access field `00` does not reprogram the channel. It freezes a copy of the running count, so that a later two-byte read returns one consistent value while counting goes on. Six waveform modes cover these uses:
- level change on terminal count
- retriggerable one-shot
- divide-by-N pulse train
- square wave
- software-started strobe
- gate-started strobe

Counting is always binary.

Top module: `pit_channel`

## Requirements
- R1: After reset `outLvl` is 1, the access field is low-then-high, and a two-byte read of the count returns 0x0000.
- R2: A control byte has this layout. Bits [5:4] are the access field. Bits [3:1] are the mode, and modes 6 and 7 act as modes 2 and 3. Bits [7:6] are ignored. An access field of `00` is a latch command and leaves the mode and the waveform untouched.
- R3: Access `01` moves the low byte only, and a load clears the high byte. Access `10` moves the high byte only, and a load clears the low byte. Access `11` moves the low byte and then the high byte, using a pointer that each data read or write flips. Any control byte other than a latch command returns the pointer to the low byte.
- R4: A latch command copies the count into a hold register. Reads return the held value until it has been fully read, which is one byte for access `01`/`10` and both bytes for `11`. Further latch commands are ignored while a held value is still unread.
- R5: The count changes only on a detected falling edge of `cntClk`, by at most one step per edge. In modes 0, 2, 3 and 4 a low `gate` stops counting.
- R6: Mode 0: a control byte selecting mode 0 drives `outLvl` low, and a load keeps it low. After N falling edges `outLvl` goes high and stays high until the next load.
- R7: Mode 1: after a `gate` rising edge, the next count edge reloads N and drives `outLvl` low. It stays low for N edges. A new rising edge before the end restarts the N-edge interval.
- R8: Mode 2: `outLvl` is low for exactly one edge out of every N edges, and N reloads by itself.
- R9: Mode 3: the count steps by two. `outLvl` is high for N/2 edges and low for N/2 edges when N is even. It is high for (N+1)/2 edges and low for (N-1)/2 edges when N is odd.
- R10: Mode 4: a load starts counting with `outLvl` high. After N edges `outLvl` is low for one edge, and nothing repeats without a new load.
- R11: Mode 5: counting starts on the first edge after a `gate` rising edge. `outLvl` is low for one edge after N further edges. A new rising edge restarts the count.
- R12: A start value of 0 counts as 65,536, so the first decrement from 0 yields 0xFFFF.
- R13: Control-byte bit 0, the decimal-count request, is ignored, and the count stays binary.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| cntClk | input | 1 | Count clock; its falling edges advance the counter |
| gate | input | 1 | Count enable or trigger, depending on mode |
| wrEn | input | 1 | Write strobe, one cycle per byte |
| rdEn | input | 1 | Read strobe, one cycle per byte |
| selCtrl | input | 1 | 1 selects the control byte, 0 selects the count data |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data; valid while rdEn is high |
| outLvl | output | 1 | Counter output waveform |

## Verification
The assertions check four properties on every cycle. The output and the count move only on a count-clock falling edge or after a host write. The hold register changes only on a latch command, and then takes the current count. There is at most one count update per cycle. The step-by-two and wrap-from-zero arithmetic is correct. The directed scenarios cover what spans many cycles: the waveform shape and period of each mode, retriggering, gate inhibit, the byte-pointer order, latch persistence, and aliasing and ignored bits in the control byte.

// File: rtl/pit_pkg.sv
`timescale 1ns/1ps
package pit_pkg;

  typedef enum logic [1:0] {
    ACC_LATCH = 2'b00,
    ACC_LOW   = 2'b01,
    ACC_HIGH  = 2'b10,
    ACC_BOTH  = 2'b11
  } access_e;

  typedef enum logic [2:0] {
    M_TERM     = 3'd0,
    M_ONESHOT  = 3'd1,
    M_RATE     = 3'd2,
    M_SQUARE   = 3'd3,
    M_SWSTROBE = 3'd4,
    M_HWSTROBE = 3'd5
  } mode_e;

  // strobes from control to datapath, at most one count update at a time
  typedef struct packed {
    logic wrLow;
    logic wrHigh;
    logic zeroLow;
    logic zeroHigh;
    logic loadCount;
    logic loadSqHigh;
    logic loadSqLow;
    logic decOne;
    logic decTwo;
    logic latch;
  } strobe_t;

endpackage

// File: rtl/pit_datapath.sv
`timescale 1ns/1ps
module pit_datapath
  import pit_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  strobe_t               st,
  input  logic [DATA_W-1:0]     wrData,
  output logic [2*DATA_W-1:0]   countVal,
  output logic [2*DATA_W-1:0]   holdVal,
  output logic                  isOne,
  output logic                  isTwo
);
  localparam int CNT_W = 2 * DATA_W;

  logic [CNT_W-1:0] reloadVal;
  logic [CNT_W-1:0] evenPart;
  logic [CNT_W-1:0] oddBump;

  // square wave: odd values get one extra step pair in the high half
  assign evenPart = {reloadVal[CNT_W-1:1], 1'b0};
  assign oddBump  = {{(CNT_W-2){1'b0}}, reloadVal[0], 1'b0};

  always_ff @(posedge clk) begin
    if (rst) begin
      reloadVal <= '0;
    end else begin
      if (st.wrLow)   reloadVal[DATA_W-1:0]     <= wrData;
      if (st.zeroLow) reloadVal[DATA_W-1:0]     <= '0;
      if (st.wrHigh)  reloadVal[CNT_W-1:DATA_W] <= wrData;
      if (st.zeroHigh) reloadVal[CNT_W-1:DATA_W] <= '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      countVal <= '0;
    end else if (st.loadCount) begin
      countVal <= reloadVal;
    end else if (st.loadSqHigh) begin
      countVal <= evenPart + oddBump;
    end else if (st.loadSqLow) begin
      countVal <= evenPart;
    end else if (st.decTwo) begin
      countVal <= countVal - CNT_W'(2);
    end else if (st.decOne) begin
      countVal <= countVal - CNT_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst)          holdVal <= '0;
    else if (st.latch) holdVal <= countVal;
  end

  assign isOne = (countVal == CNT_W'(1));
  assign isTwo = (countVal == CNT_W'(2));

endmodule

// File: rtl/pit_ctrl.sv
`timescale 1ns/1ps
module pit_ctrl
  import pit_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  cntClk,
  input  logic                  gate,
  input  logic                  wrEn,
  input  logic                  rdEn,
  input  logic                  selCtrl,
  input  logic [DATA_W-1:0]     wrData,
  input  logic [2*DATA_W-1:0]   countVal,
  input  logic [2*DATA_W-1:0]   holdVal,
  input  logic                  isOne,
  input  logic                  isTwo,
  output strobe_t               st,
  output logic [DATA_W-1:0]     rdData,
  output logic                  outLvl
);
  localparam int CNT_W = 2 * DATA_W;

  mode_e   mode, nMode, newMode;
  access_e acc, nAcc, newAcc;
  logic bytePtr, nPtr;
  logic latched, nLatched;
  logic running, nRun;
  logic trigPend, nTrig;
  logic pulse, nPulse;
  logic loadPend, nLoadPend;
  logic nOut;
  logic prevClk, prevGate;
  logic tick, gateRise, ctrlWr, dataWr, dataRd, reprogram, gateTrig;
  logic hiSel;
  logic [CNT_W-1:0] readSrc;
  logic unusedCtrlBits;

  assign unusedCtrlBits = ^{wrData[DATA_W-1:6], wrData[0]};

  assign tick     = prevClk & ~cntClk;
  assign gateRise = gate & ~prevGate;
  assign ctrlWr   = wrEn & selCtrl;
  assign dataWr   = wrEn & ~selCtrl;
  assign dataRd   = rdEn & ~selCtrl;
  assign newAcc   = access_e'(wrData[5:4]);
  // modes 6 and 7 fold onto 2 and 3
  assign newMode  = (wrData[3:2] == 2'b11) ? mode_e'({1'b0, wrData[2:1]})
                                           : mode_e'(wrData[3:1]);
  assign reprogram = ctrlWr && (newAcc != ACC_LATCH);
  assign gateTrig  = (mode == M_ONESHOT) || (mode == M_HWSTROBE);

  always_comb begin
    st = '0;
    nMode = mode; nAcc = acc; nPtr = bytePtr; nLatched = latched;
    nRun = running; nTrig = trigPend; nPulse = pulse; nLoadPend = loadPend;
    nOut = outLvl;

    if (ctrlWr && newAcc == ACC_LATCH) begin
      if (!latched) begin
        st.latch = 1'b1;
        nLatched = 1'b1;
      end
    end

    if (reprogram) begin
      nMode = newMode; nAcc = newAcc; nPtr = 1'b0; nLatched = 1'b0;
      nRun = 1'b0; nTrig = 1'b0; nPulse = 1'b0; nLoadPend = 1'b0;
      nOut = (newMode != M_TERM);
    end else begin
      if (loadPend) begin
        nLoadPend = 1'b0;
        nTrig = 1'b0;
        nPulse = 1'b0;
        case (mode)
          M_TERM:   begin st.loadCount = 1'b1;  nOut = 1'b0; nRun = 1'b1; end
          M_SQUARE: begin st.loadSqHigh = 1'b1; nOut = 1'b1; nRun = 1'b1; end
          M_RATE, M_SWSTROBE: begin st.loadCount = 1'b1; nOut = 1'b1; nRun = 1'b1; end
          default:  begin nOut = 1'b1; nRun = 1'b0; end
        endcase
      end else if (tick) begin
        if (gateTrig && trigPend) begin
          st.loadCount = 1'b1;
          nTrig = 1'b0; nRun = 1'b1; nPulse = 1'b0;
          nOut = (mode == M_HWSTROBE);
        end else if (pulse) begin
          nOut = 1'b1; nPulse = 1'b0;
        end else if (running && (gate || gateTrig)) begin
          case (mode)
            M_TERM, M_ONESHOT: begin
              st.decOne = 1'b1;
              if (isOne) begin nOut = 1'b1; nRun = 1'b0; end
            end
            M_SWSTROBE, M_HWSTROBE: begin
              st.decOne = 1'b1;
              if (isOne) begin nOut = 1'b0; nPulse = 1'b1; nRun = 1'b0; end
            end
            M_RATE: begin
              if (isOne) begin st.loadCount = 1'b1; nOut = 1'b1; end
              else begin st.decOne = 1'b1; if (isTwo) nOut = 1'b0; end
            end
            M_SQUARE: begin
              if (isTwo) begin
                nOut = ~outLvl;
                if (outLvl) st.loadSqLow = 1'b1;
                else        st.loadSqHigh = 1'b1;
              end else begin
                st.decTwo = 1'b1;
              end
            end
            default: ;
          endcase
        end
      end
      if (gateRise && gateTrig) nTrig = 1'b1;

      if (dataRd) begin
        if (acc == ACC_BOTH) begin
          nPtr = ~bytePtr;
          if (bytePtr) nLatched = 1'b0;
        end else begin
          nLatched = 1'b0;
        end
      end

      if (dataWr) begin
        case (acc)
          ACC_LOW:  begin st.wrLow = 1'b1;  st.zeroHigh = 1'b1; nLoadPend = 1'b1; end
          ACC_HIGH: begin st.wrHigh = 1'b1; st.zeroLow = 1'b1;  nLoadPend = 1'b1; end
          default: begin
            if (!bytePtr) begin st.wrLow = 1'b1; nPtr = 1'b1; end
            else begin st.wrHigh = 1'b1; nPtr = 1'b0; nLoadPend = 1'b1; end
          end
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode <= M_TERM; acc <= ACC_BOTH; bytePtr <= 1'b0; latched <= 1'b0;
      running <= 1'b0; trigPend <= 1'b0; pulse <= 1'b0; loadPend <= 1'b0;
      outLvl <= 1'b1; prevClk <= 1'b0; prevGate <= 1'b0;
    end else begin
      mode <= nMode; acc <= nAcc; bytePtr <= nPtr; latched <= nLatched;
      running <= nRun; trigPend <= nTrig; pulse <= nPulse; loadPend <= nLoadPend;
      outLvl <= nOut; prevClk <= cntClk; prevGate <= gate;
    end
  end

  assign readSrc = latched ? holdVal : countVal;
  assign hiSel   = (acc == ACC_HIGH) || (acc == ACC_BOTH && bytePtr);
  assign rdData  = hiSel ? readSrc[CNT_W-1:DATA_W] : readSrc[DATA_W-1:0];

endmodule

// File: rtl/pit_channel.sv
`timescale 1ns/1ps
module pit_channel
  import pit_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cntClk,
  input  logic              gate,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic              selCtrl,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              outLvl
);
  localparam int CNT_W = 2 * DATA_W;

  strobe_t          st;
  logic [CNT_W-1:0] countVal;
  logic [CNT_W-1:0] holdVal;
  logic             isOne;
  logic             isTwo;

  pit_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rst(rst), .cntClk(cntClk), .gate(gate),
    .wrEn(wrEn), .rdEn(rdEn), .selCtrl(selCtrl), .wrData(wrData),
    .countVal(countVal), .holdVal(holdVal), .isOne(isOne), .isTwo(isTwo),
    .st(st), .rdData(rdData), .outLvl(outLvl)
  );

  pit_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rst(rst), .st(st), .wrData(wrData),
    .countVal(countVal), .holdVal(holdVal), .isOne(isOne), .isTwo(isTwo)
  );

endmodule

// File: rtl/pit_channel_chk.sv
`timescale 1ns/1ps
module pit_channel_chk
  import pit_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             cntClk,
  input logic             wrEn,
  input logic             outLvl,
  input logic [CNT_W-1:0] countVal,
  input logic [CNT_W-1:0] holdVal,
  input strobe_t          st
);

  // R5: without a count edge or host write, the output holds
  a_r5_out_quiet: assert property (@(posedge clk) disable iff (rst)
    (!($past(cntClk) && !cntClk) && !wrEn && !$past(wrEn)) |=> $stable(outLvl));

  // R5: decrements happen only on a detected falling count edge
  a_r5_dec_on_edge: assert property (@(posedge clk) disable iff (rst)
    (st.decOne || st.decTwo) |-> ($past(cntClk) && !cntClk));

  // R5: at most one count update per cycle
  a_r5_one_update: assert property (@(posedge clk) disable iff (rst)
    $onehot0({st.loadCount, st.loadSqHigh, st.loadSqLow, st.decOne, st.decTwo}));

  // R4: hold register captures the count on a latch command
  a_r4_hold_capture: assert property (@(posedge clk) disable iff (rst)
    st.latch |=> (holdVal == $past(countVal)));

  // R4: hold register frozen otherwise
  a_r4_hold_frozen: assert property (@(posedge clk) disable iff (rst)
    !st.latch |=> $stable(holdVal));

  // R12: decrement from zero wraps to all ones
  a_r12_zero_wrap: assert property (@(posedge clk) disable iff (rst)
    (st.decOne && countVal == '0) |=> (countVal == '1));

  // R9: square-wave stepping is by two
  a_r9_step_two: assert property (@(posedge clk) disable iff (rst)
    st.decTwo |=> (countVal == $past(countVal) - CNT_W'(2)));

endmodule

bind pit_channel pit_channel_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .cntClk(cntClk), .wrEn(wrEn), .outLvl(outLvl),
  .countVal(countVal), .holdVal(holdVal), .st(st)
);

// File: tb/sim_pit_channel.sv
`timescale 1ns/1ps
module sim_pit_channel;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cntClk = 1'b0;
  logic       gate = 1'b0;
  logic       wrEn = 1'b0;
  logic       rdEn = 1'b0;
  logic       selCtrl = 1'b0;
  logic [7:0] wrData = 8'h00;
  logic [7:0] rdData;
  logic       outLvl;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  pit_channel u0 (
    .clk(clk), .rst(rst), .cntClk(cntClk), .gate(gate),
    .wrEn(wrEn), .rdEn(rdEn), .selCtrl(selCtrl), .wrData(wrData),
    .rdData(rdData), .outLvl(outLvl)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic busWrite(input logic isCtrl, input logic [7:0] v);
    @(negedge clk);
    selCtrl = isCtrl; wrData = v; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0; selCtrl = 1'b0;
  endtask

  task automatic loadWord(input logic [15:0] v);
    busWrite(1'b0, v[7:0]);
    busWrite(1'b0, v[15:8]);
    @(negedge clk);
  endtask

  task automatic readByte(output logic [7:0] v);
    @(negedge clk);
    selCtrl = 1'b0; rdEn = 1'b1;
    #2 v = rdData;
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  task automatic readWord(output logic [15:0] v);
    logic [7:0] lo, hi;
    readByte(lo);
    readByte(hi);
    v = {hi, lo};
  endtask

  task automatic latchRead(output logic [15:0] v);
    busWrite(1'b1, 8'h00);
    readWord(v);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); cntClk = 1'b1;
      @(negedge clk); cntClk = 1'b0;
    end
    @(negedge clk);
  endtask

  task automatic gateRise();
    @(negedge clk); gate = 1'b0;
    @(negedge clk); gate = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_reset();
    logic [15:0] v;
    check("R1 out after reset", 16'(outLvl), 16'h1);
    readWord(v);
    check("R1 count after reset", v, 16'h0000);
  endtask

  task automatic t_access();
    logic [7:0] b;
    logic [15:0] v;
    gate = 1'b1;
    busWrite(1'b1, 8'h10);           // low-only, mode 0
    busWrite(1'b0, 8'h34);
    readByte(b);
    check("R3 low-only read", 16'(b), 16'h0034);
    readByte(b);
    check("R3 low-only read repeat", 16'(b), 16'h0034);
    busWrite(1'b1, 8'h20);           // high-only
    busWrite(1'b0, 8'h12);
    readByte(b);
    check("R3 high-only read", 16'(b), 16'h0012);
    busWrite(1'b1, 8'h30);
    busWrite(1'b0, 8'hAB);           // half a load, then abandoned
    busWrite(1'b1, 8'h30);           // pointer back to low
    loadWord(16'h0005);
    readWord(v);
    check("R3 pointer reset by control", v, 16'h0005);
  endtask

  task automatic t_latch_bcd();
    logic [15:0] v;
    gate = 1'b1;
    busWrite(1'b1, 8'h31);           // bit0 set, must stay binary
    loadWord(16'h0010);
    ticks(1);
    latchRead(v);
    check("R13 binary count with bit0 set", v, 16'h000F);
    busWrite(1'b1, 8'h00);
    ticks(3);
    readWord(v);
    check("R4 held value after ticks", v, 16'h000F);
    readWord(v);
    check("R4 live value after hold read", v, 16'h000C);
    busWrite(1'b1, 8'h00);
    ticks(2);
    busWrite(1'b1, 8'h00);           // ignored, hold still unread
    ticks(1);
    readWord(v);
    check("R4 second latch ignored", v, 16'h000C);
  endtask

  task automatic t_zero();
    logic [15:0] v;
    gate = 1'b1;
    busWrite(1'b1, 8'h30);
    loadWord(16'h0000);
    ticks(1);
    latchRead(v);
    check("R12 zero wraps to FFFF", v, 16'hFFFF);
    check("R12 out still low", 16'(outLvl), 16'h0);
  endtask

  task automatic t_mode0();
    logic [15:0] v;
    gate = 1'b0;
    busWrite(1'b1, 8'h30);
    check("R6 control drives out low", 16'(outLvl), 16'h0);
    loadWord(16'h0003);
    ticks(5);
    check("R5 gate low holds out", 16'(outLvl), 16'h0);
    latchRead(v);
    check("R5 gate low holds count", v, 16'h0003);
    gate = 1'b1;
    ticks(2);
    check("R6 out low before terminal", 16'(outLvl), 16'h0);
    ticks(1);
    check("R6 out high at terminal", 16'(outLvl), 16'h1);
    ticks(2);
    check("R6 out stays high", 16'(outLvl), 16'h1);
    loadWord(16'h0002);
    check("R6 reload drives low", 16'(outLvl), 16'h0);
    @(negedge clk); cntClk = 1'b1;
    repeat (4) @(negedge clk);
    latchRead(v);
    check("R5 rising count edge ignored", v, 16'h0002);
    cntClk = 1'b0;
    repeat (2) @(negedge clk);
    latchRead(v);
    check("R5 falling count edge counts", v, 16'h0001);
  endtask

  task automatic t_mode1();
    gate = 1'b0;
    busWrite(1'b1, 8'h32);
    loadWord(16'h0003);
    ticks(2);
    check("R7 no trigger, out high", 16'(outLvl), 16'h1);
    gateRise();
    ticks(1);
    check("R7 out low after trigger", 16'(outLvl), 16'h0);
    ticks(2);
    check("R7 out low before end", 16'(outLvl), 16'h0);
    ticks(1);
    check("R7 out high after N", 16'(outLvl), 16'h1);
    gateRise();
    ticks(2);
    gateRise();                      // retrigger mid-pulse
    ticks(3);
    check("R7 retrigger extends pulse", 16'(outLvl), 16'h0);
    ticks(1);
    check("R7 out high after retrigger N", 16'(outLvl), 16'h1);
  endtask

  task automatic t_mode2();
    logic [15:0] v;
    gate = 1'b1;
    busWrite(1'b1, 8'h74);           // select bits set, ignored
    loadWord(16'h0004);
    ticks(2);
    check("R8 out high early", 16'(outLvl), 16'h1);
    latchRead(v);
    check("R2 latch keeps mode, count", v, 16'h0002);
    ticks(1);
    check("R8 out low pulse", 16'(outLvl), 16'h0);
    ticks(1);
    check("R8 out high after pulse", 16'(outLvl), 16'h1);
    ticks(2);
    check("R8 second period high", 16'(outLvl), 16'h1);
    ticks(1);
    check("R8 second period pulse", 16'(outLvl), 16'h0);
  endtask

  task automatic t_mode3();
    gate = 1'b1;
    busWrite(1'b1, 8'h3E);           // mode 7 aliases mode 3
    loadWord(16'h0005);
    ticks(2);
    check("R9 odd high half", 16'(outLvl), 16'h1);
    ticks(1);
    check("R2 R9 odd low starts after 3", 16'(outLvl), 16'h0);
    ticks(1);
    check("R9 odd still low", 16'(outLvl), 16'h0);
    ticks(1);
    check("R9 odd high after 2 low", 16'(outLvl), 16'h1);
    busWrite(1'b1, 8'h36);
    loadWord(16'h0004);
    ticks(1);
    check("R9 even high half", 16'(outLvl), 16'h1);
    ticks(1);
    check("R9 even low after 2", 16'(outLvl), 16'h0);
    ticks(2);
    check("R9 even high after 2 low", 16'(outLvl), 16'h1);
  endtask

  task automatic t_mode4();
    gate = 1'b1;
    busWrite(1'b1, 8'h38);
    loadWord(16'h0003);
    ticks(2);
    check("R10 out high while counting", 16'(outLvl), 16'h1);
    ticks(1);
    check("R10 strobe low", 16'(outLvl), 16'h0);
    ticks(1);
    check("R10 strobe one edge", 16'(outLvl), 16'h1);
    ticks(3);
    check("R10 no repeat", 16'(outLvl), 16'h1);
  endtask

  task automatic t_mode5();
    gate = 1'b0;
    busWrite(1'b1, 8'h3A);
    loadWord(16'h0002);
    ticks(3);
    check("R11 waits for gate", 16'(outLvl), 16'h1);
    gateRise();
    ticks(2);
    check("R11 high before terminal", 16'(outLvl), 16'h1);
    ticks(1);
    check("R11 strobe low", 16'(outLvl), 16'h0);
    ticks(1);
    check("R11 strobe one edge", 16'(outLvl), 16'h1);
    gateRise();
    ticks(3);
    check("R11 retrigger strobes again", 16'(outLvl), 16'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_access();
    t_latch_bcd();
    t_zero();
    t_mode0();
    t_mode1();
    t_mode2();
    t_mode3();
    t_mode4();
    t_mode5();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule